// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Freezable Host View

This block keeps time of day and calendar date as packed BCD bytes: hundredths of a second, seconds, minutes, hours, weekday, day of month, month and two-digit year. An external 100 Hz single-cycle enable advances the count. Month lengths, including the extra February day in years divisible by four, are handled in hardware. Hours count either in 24-hour form or in 12-hour form with a PM flag.

Two copies of the time exist. The running set always advances. The host-visible set normally follows it. Clearing the transfer-enable bit freezes the visible set, so the host can read a coherent snapshot while the running set keeps counting. Writes made while frozen go into the visible set only. Setting transfer-enable again copies just those written bytes into the running set, and the unwritten fields keep the time that elapsed meanwhile.

The host uses a byte-wide port with a write strobe and an address. Read data is registered and appears one cycle after the address is presented.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, offsets 0, 1, 2, 4 and A read 00, offsets 6, 8 and 9 read 01, and offset B reads 80h (transfer enabled).
- R2: Each tick while the clock runs adds one to offset 0 in BCD (tenths in bits 7:4, hundredths in bits 3:0). 99 wraps to 00 and carries into seconds (offset 1). Seconds and minutes (offset 2) each wrap from 59 to 00 with a carry onward.
- R3: With hours bit 6 clear (24-hour form), bits 5:0 of offset 4 hold BCD hours 00 to 23. A carry out of 23 gives 00 and advances the weekday and the date.
- R4: With hours bit 6 set (12-hour form), bit 5 is PM and bits 4:0 hold 01 to 12. 11 AM becomes 12 PM with no day carry. 11 PM becomes 12 AM with a day carry. 12 becomes 01 and the PM flag is kept.
- R5: The weekday (offset 6, 01 to 07) wraps 07 to 01. The date (offset 8) wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 28 for month 02 (29 when the BCD year is divisible by 4), and 31 otherwise. This carries the month (offset 9, bits 4:0), which wraps 12 to 01 and carries the year (offset A), which wraps 99 to 00.
- R6: Month bit 7 set stops all counting. Month bit 6 is a plain stored bit with no effect on counting.
- R7: Bits that have no meaning read 0 whatever was written. The masks are: offset 1 and 2 use 7Fh, offset 4 uses 7Fh, offset 6 uses 07h, offset 8 uses 3Fh and offset 9 uses DFh. Offsets 3, 5, 7 and C to F read 00 and ignore writes. Bits 6:0 of offset B read 0.
- R8: Read data is registered. It shows the value visible in the cycle the address was presented, one clock later, and reads 00 during reset.
- R9: Writing offset B with bit 7 = 0 freezes the visible time bytes at the value shown in that cycle, while the running set keeps counting. Writing bit 7 = 1 makes the visible bytes show the running time again, with no lost ticks.
- R10: While frozen, writes to time bytes are visible on read at once. On the 0-to-1 transfer-enable write, only the written bytes are loaded into the running set. All other fields keep their running values.
- R11: A write to a time byte that lands in the same cycle as a tick replaces that byte with the written value (any carry into it is lost), while the other bytes advance. The same holds for bytes loaded at the transfer-enable release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 100 Hz count enable |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | ADDR_W | Host register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data for the previous cycle's address |

## Verification
A host write to a time byte and a tick can land in the same cycle, and so can the release of the freeze and a tick. The bench drives the write strobe and the tick together while the hundredths byte sits at 99, so a carry is aimed at the written byte. It then reads back both the written byte and its neighbours. The behavioural model applies the tick first and the write override second, and a byte-for-byte comparison on every clock judges whether the carry was dropped and the other fields advanced.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NSLOT = 8;

  typedef logic [7:0] rbyte_t;
  typedef logic [NSLOT-1:0][7:0] tset_t;

  // Slot order inside the time set; the host offset map is decoded separately.
  localparam int S_HSEC = 0;
  localparam int S_SEC  = 1;
  localparam int S_MIN  = 2;
  localparam int S_HOUR = 3;
  localparam int S_WDAY = 4;
  localparam int S_DATE = 5;
  localparam int S_MON  = 6;
  localparam int S_YEAR = 7;

  function automatic rbyte_t slot_mask(input logic [2:0] s);
    case (s)
      3'd1, 3'd2, 3'd3: slot_mask = 8'h7F;
      3'd4:             slot_mask = 8'h07;
      3'd5:             slot_mask = 8'h3F;
      3'd6:             slot_mask = 8'hDF;
      default:          slot_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    bcd_inc8 = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] bcd_inc6(input logic [5:0] v);
    bcd_inc6 = (v[3:0] >= 4'd9) ? {v[5:4] + 2'd1, 4'd0} : {v[5:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [4:0] bcd_inc5(input logic [4:0] v);
    bcd_inc5 = (v[3:0] >= 4'd9) ? 5'h10 : {v[4], v[3:0] + 4'd1};
  endfunction

  // Divisible by four in BCD: even tens with units 0/4/8, odd tens with 2/6.
  function automatic logic leap_yr(input logic [7:0] y);
    if (y[4]) leap_yr = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      leap_yr = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [4:0] m, input logic leap);
    case (m)
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
#(
  parameter tset_t RESET_TIME = 64'h0001_0101_0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [NSLOT-1:0] ld_mask_i,
  input  tset_t            ld_data_i,
  output tset_t            cur_o
);
  tset_t cur_q, adv, nxt;
  logic run, c_hs, c_s, c_m, c_h, c_d, c_mo;
  logic pm;
  logic [4:0] h12, mo_n;
  logic [5:0] h24;

  // Ripple of BCD carries from hundredths up to years, all in one cycle.
  always_comb begin
    adv  = cur_q;
    run  = tick_i && !cur_q[S_MON][7];
    c_hs = 1'b0; c_s = 1'b0; c_m = 1'b0; c_h = 1'b0; c_d = 1'b0; c_mo = 1'b0;
    pm   = cur_q[S_HOUR][5];
    h12  = cur_q[S_HOUR][4:0];
    h24  = cur_q[S_HOUR][5:0];
    mo_n = bcd_inc5(cur_q[S_MON][4:0]);
    if (run) begin
      c_hs = cur_q[S_HSEC] >= 8'h99;
      adv[S_HSEC] = c_hs ? 8'h00 : bcd_inc8(cur_q[S_HSEC]);
    end
    if (c_hs) begin
      c_s = cur_q[S_SEC] >= 8'h59;
      adv[S_SEC] = c_s ? 8'h00 : bcd_inc8(cur_q[S_SEC]);
    end
    if (c_s) begin
      c_m = cur_q[S_MIN] >= 8'h59;
      adv[S_MIN] = c_m ? 8'h00 : bcd_inc8(cur_q[S_MIN]);
    end
    if (c_m) begin
      if (cur_q[S_HOUR][6]) begin
        if (h12 == 5'h11) begin
          c_h = pm;
          pm  = !pm;
          h12 = 5'h12;
        end else if (h12 >= 5'h12) begin
          h12 = 5'h01;
        end else begin
          h12 = bcd_inc5(h12);
        end
        adv[S_HOUR] = {2'b01, pm, h12};
      end else begin
        if (h24 >= 6'h23) begin
          h24 = 6'h00;
          c_h = 1'b1;
        end else begin
          h24 = bcd_inc6(h24);
        end
        adv[S_HOUR] = {2'b00, h24};
      end
    end
    if (c_h) begin
      adv[S_WDAY] = (cur_q[S_WDAY][2:0] == 3'd7 || cur_q[S_WDAY][2:0] == 3'd0) ?
                    8'h01 : {5'b0, cur_q[S_WDAY][2:0] + 3'd1};
      c_d = cur_q[S_DATE] >= last_day(cur_q[S_MON][4:0], leap_yr(cur_q[S_YEAR]));
      adv[S_DATE] = c_d ? 8'h01 : {2'b00, bcd_inc6(cur_q[S_DATE][5:0])};
    end
    if (c_d) begin
      c_mo = cur_q[S_MON][4:0] >= 5'h12;
      adv[S_MON] = {cur_q[S_MON][7:5], c_mo ? 5'h01 : mo_n};
    end
    if (c_mo) begin
      adv[S_YEAR] = (cur_q[S_YEAR] >= 8'h99) ? 8'h00 : bcd_inc8(cur_q[S_YEAR]);
    end
  end

  // Host loads override the advanced value byte by byte.
  always_comb begin
    nxt = adv;
    for (int i = 0; i < NSLOT; i++) begin
      if (ld_mask_i[i]) nxt[i] = ld_data_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= RESET_TIME;
    else     cur_q <= nxt;
  end

  assign cur_o = cur_q;

  p_hsec_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !ld_mask_i[S_HSEC]) |=> (cur_q[S_HSEC] != $past(cur_q[S_HSEC])));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && ld_mask_i == '0) |=> $stable(cur_q));

  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cur_q[S_MON][7] && ld_mask_i == '0) |=> $stable(cur_q));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
    ld_mask_i[S_SEC] |=> (cur_q[S_SEC] == $past(ld_data_i[S_SEC])));
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_pkg::*;
#(
  parameter int    ADDR_W     = 4,
  parameter logic  TE_RESET   = 1'b1,
  parameter tset_t RESET_TIME = 64'h0001_0101_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  tset_t             cur_i,
  output logic [NSLOT-1:0]  ld_mask_o,
  output tset_t             ld_data_o,
  output logic [7:0]        rdata_o
);
  localparam logic [3:0] CMD_OFS = 4'hB;

  tset_t            vis_q, src;
  logic [NSLOT-1:0] dirty_q;
  logic             te_q;
  logic [7:0]       rdata_q, rd_next, wval;
  logic             hi_zero, is_time, is_cmd, release_w;
  logic [2:0]       slot;

  always_comb begin
    hi_zero = ((addr_i >> 4) == '0);
    is_time = hi_zero;
    slot    = 3'd0;
    case (addr_i[3:0])
      4'h0:    slot = 3'd0;
      4'h1:    slot = 3'd1;
      4'h2:    slot = 3'd2;
      4'h4:    slot = 3'd3;
      4'h6:    slot = 3'd4;
      4'h8:    slot = 3'd5;
      4'h9:    slot = 3'd6;
      4'hA:    slot = 3'd7;
      default: is_time = 1'b0;
    endcase
    is_cmd    = hi_zero && (addr_i[3:0] == CMD_OFS);
    wval      = wdata_i & slot_mask(slot);
    release_w = wr_en_i && is_cmd && !te_q && wdata_i[7];
  end

  always_comb begin
    ld_mask_o = '0;
    ld_data_o = vis_q;
    if (release_w) begin
      ld_mask_o = dirty_q;
    end else if (wr_en_i && is_time && te_q) begin
      ld_mask_o[slot] = 1'b1;
      ld_data_o[slot] = wval;
    end
  end

  always_comb begin
    src = te_q ? cur_i : vis_q;
    if (is_time)     rd_next = src[slot];
    else if (is_cmd) rd_next = {te_q, 7'b0};
    else             rd_next = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q   <= RESET_TIME;
      dirty_q <= '0;
      te_q    <= TE_RESET;
      rdata_q <= 8'h00;
    end else begin
      rdata_q <= rd_next;
      if (te_q)                       vis_q <= cur_i;
      else if (wr_en_i && is_time)    vis_q[slot] <= wval;
      if (release_w)                  dirty_q <= '0;
      else if (wr_en_i && is_time && !te_q) dirty_q[slot] <= 1'b1;
      if (wr_en_i && is_cmd)          te_q <= wdata_i[7];
    end
  end

  assign rdata_o = rdata_q;

  p_live_clean_r10: assert property (@(posedge clk) disable iff (rst)
    te_q |-> (dirty_q == '0));

  p_release_done_r10: assert property (@(posedge clk) disable iff (rst)
    release_w |=> (te_q && dirty_q == '0));

  p_frozen_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!te_q && !(wr_en_i && is_time)) |=> $stable(vis_q));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!is_time && !is_cmd) |=> (rdata_o == 8'h00));

  p_sec_msb_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (is_time && slot == 3'd1) |=> (rdata_o[7] == 1'b0));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int    ADDR_W     = 4,
  parameter logic  TE_RESET   = 1'b1,
  parameter tset_t RESET_TIME = 64'h0001_0101_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  tset_t            cur;
  tset_t            ld_data;
  logic [NSLOT-1:0] ld_mask;

  rtc_time_counter #(.RESET_TIME(RESET_TIME)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .ld_mask_i (ld_mask),
    .ld_data_i (ld_data),
    .cur_o     (cur)
  );

  rtc_host_port #(
    .ADDR_W     (ADDR_W),
    .TE_RESET   (TE_RESET),
    .RESET_TIME (RESET_TIME)
  ) u_port (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cur_i     (cur),
    .ld_mask_o (ld_mask),
    .ld_data_o (ld_data),
    .rdata_o   (rdata_o)
  );
endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, tick, wr;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;

  int    checks = 0, fails = 0, cycles = 0;
  string tag = "R8";
  bit    started = 0;

  // Behavioural reference state
  int m_hs, m_s, m_mi, m_h24, m_wd, m_dt, m_mo, m_yr, exp_rd;
  bit m_md12, m_osc, m_b6, m_te;
  int m_vis[8];
  bit m_dirty[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_core u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic int b2i(int x); return ((x >> 4) & 15) * 10 + (x & 15); endfunction
  function automatic int i2b(int v); return ((v / 10) << 4) | (v % 10); endfunction

  function automatic int slot_of(int a);
    case (a)
      0: return 0; 1: return 1; 2: return 2; 4: return 3;
      6: return 4; 8: return 5; 9: return 6; 10: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int msk(int s);
    case (s)
      1, 2, 3: return 'h7F;
      4: return 'h07;
      5: return 'h3F;
      6: return 'hDF;
      default: return 'hFF;
    endcase
  endfunction

  function automatic int enc(int s);
    int h;
    case (s)
      0: return i2b(m_hs);
      1: return i2b(m_s);
      2: return i2b(m_mi);
      3: begin
        if (m_md12) begin
          h = (m_h24 % 12 == 0) ? 12 : m_h24 % 12;
          return 'h40 | ((m_h24 >= 12) ? 'h20 : 0) | i2b(h);
        end
        return i2b(m_h24);
      end
      4: return m_wd;
      5: return i2b(m_dt);
      6: return (int'(m_osc) << 7) | (int'(m_b6) << 6) | i2b(m_mo);
      default: return i2b(m_yr);
    endcase
  endfunction

  task automatic dec(int s, int b);
    case (s)
      0: m_hs = b2i(b);
      1: m_s  = b2i(b);
      2: m_mi = b2i(b);
      3: begin
        m_md12 = b[6];
        if (m_md12) m_h24 = (b2i(b & 'h1F) % 12) + (b[5] ? 12 : 0);
        else        m_h24 = b2i(b & 'h3F);
      end
      4: m_wd = b & 7;
      5: m_dt = b2i(b);
      6: begin m_osc = b[7]; m_b6 = b[6]; m_mo = b2i(b & 'h1F); end
      default: m_yr = b2i(b);
    endcase
  endtask

  function automatic int month_len(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic advance();
    m_hs++;
    if (m_hs == 100) begin
      m_hs = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_h24++;
          if (m_h24 == 24) begin
            m_h24 = 0;
            m_wd = (m_wd >= 7) ? 1 : m_wd + 1;
            if (m_dt >= month_len(m_mo, m_yr)) begin
              m_dt = 1; m_mo++;
              if (m_mo == 13) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
            end else m_dt++;
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      started = 1;
      m_hs = 0; m_s = 0; m_mi = 0; m_h24 = 0; m_md12 = 0; m_wd = 1;
      m_dt = 1; m_mo = 1; m_yr = 0; m_osc = 0; m_b6 = 0; m_te = 1;
      for (int i = 0; i < 8; i++) begin m_vis[i] = 0; m_dirty[i] = 0; end
      exp_rd = 0;
    end else begin
      int sl, v;
      bit old_te;
      sl = slot_of(int'(addr));
      old_te = m_te;
      if (sl >= 0)          exp_rd = old_te ? enc(sl) : m_vis[sl];
      else if (addr == 11)  exp_rd = int'(old_te) << 7;
      else                  exp_rd = 0;
      if (old_te) for (int i = 0; i < 8; i++) m_vis[i] = enc(i);
      if (tick && !m_osc) advance();
      if (wr) begin
        if (addr == 11) begin
          if (!old_te && wdata[7]) begin
            for (int i = 0; i < 8; i++) if (m_dirty[i]) dec(i, m_vis[i]);
            for (int i = 0; i < 8; i++) m_dirty[i] = 0;
          end
          m_te = wdata[7];
        end else if (sl >= 0) begin
          v = int'(wdata) & msk(sl);
          if (old_te) dec(sl, v);
          else begin m_vis[sl] = v; m_dirty[sl] = 1; end
        end
      end
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (int'(rdata) != exp_rd) begin
        fails++;
        $display("FAIL %s model compare addr=%h: actual %h expected %h", tag, addr, rdata, exp_rd[7:0]);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(bit w, int a, int d, bit t);
    @(negedge clk);
    wr = w; addr = a[3:0]; wdata = d[7:0]; tick = t;
  endtask

  task automatic rd_chk(int a, int e, string r);
    cyc(0, a, 0, 0);
    @(negedge clk);
    checks++;
    if (int'(rdata) != e) begin
      fails++;
      $display("FAIL %s read offset %h: actual %h expected %h", r, a, rdata, e[7:0]);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) cyc(0, 0, 0, 1);
  endtask

  task automatic set_time(int hs, int s, int mi, int h, int wd, int dt, int mo, int yr);
    cyc(1, 0, hs, 0); cyc(1, 1, s, 0); cyc(1, 2, mi, 0); cyc(1, 4, h, 0);
    cyc(1, 6, wd, 0); cyc(1, 8, dt, 0); cyc(1, 9, mo, 0); cyc(1, 10, yr, 0);
  endtask

  initial begin
    rst = 1; tick = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    tag = "R1";
    rd_chk(0, 'h00, "R1"); rd_chk(1, 'h00, "R1"); rd_chk(2, 'h00, "R1");
    rd_chk(4, 'h00, "R1"); rd_chk(6, 'h01, "R1"); rd_chk(8, 'h01, "R1");
    rd_chk(9, 'h01, "R1"); rd_chk(10, 'h00, "R1"); rd_chk(11, 'h80, "R1");

    tag = "R2";
    set_time('h98, 'h59, 'h59, 'h05, 2, 'h10, 'h05, 'h20);
    ticks(3);
    rd_chk(0, 'h01, "R2"); rd_chk(1, 'h00, "R2"); rd_chk(2, 'h00, "R2"); rd_chk(4, 'h06, "R2");

    tag = "R3";
    set_time('h99, 'h59, 'h59, 'h23, 7, 'h15, 'h03, 'h24);
    ticks(1);
    rd_chk(4, 'h00, "R3"); rd_chk(6, 'h01, "R3"); rd_chk(8, 'h16, "R3");

    tag = "R4";
    set_time('h99, 'h59, 'h59, 'h71, 3, 'h10, 'h05, 'h10);
    ticks(1);
    rd_chk(4, 'h52, "R4"); rd_chk(8, 'h11, "R4");
    set_time('h99, 'h59, 'h59, 'h51, 3, 'h10, 'h05, 'h10);
    ticks(1);
    rd_chk(4, 'h72, "R4"); rd_chk(8, 'h10, "R4");
    set_time('h99, 'h59, 'h59, 'h72, 3, 'h10, 'h05, 'h10);
    ticks(1);
    rd_chk(4, 'h61, "R4");

    tag = "R5";
    set_time('h99, 'h59, 'h59, 'h23, 1, 'h28, 'h02, 'h24);
    ticks(1);
    rd_chk(8, 'h29, "R5"); rd_chk(9, 'h02, "R5");
    set_time('h99, 'h59, 'h59, 'h23, 1, 'h29, 'h02, 'h24);
    ticks(1);
    rd_chk(8, 'h01, "R5"); rd_chk(9, 'h03, "R5");
    set_time('h99, 'h59, 'h59, 'h23, 1, 'h28, 'h02, 'h23);
    ticks(1);
    rd_chk(8, 'h01, "R5"); rd_chk(9, 'h03, "R5");
    set_time('h99, 'h59, 'h59, 'h23, 1, 'h30, 'h04, 'h23);
    ticks(1);
    rd_chk(8, 'h01, "R5"); rd_chk(9, 'h05, "R5");
    set_time('h99, 'h59, 'h59, 'h23, 1, 'h30, 'h01, 'h23);
    ticks(1);
    rd_chk(8, 'h31, "R5");
    set_time('h99, 'h59, 'h59, 'h23, 7, 'h31, 'h12, 'h99);
    ticks(1);
    rd_chk(8, 'h01, "R5"); rd_chk(9, 'h01, "R5"); rd_chk(10, 'h00, "R5"); rd_chk(6, 'h01, "R5");

    tag = "R6";
    set_time('h40, 'h10, 'h20, 'h08, 2, 'h05, 'h81, 'h25);
    ticks(10);
    rd_chk(0, 'h40, "R6"); rd_chk(9, 'h81, "R6");
    cyc(1, 9, 'h41, 0);
    ticks(5);
    rd_chk(0, 'h45, "R6"); rd_chk(9, 'h41, "R6");

    tag = "R7";
    cyc(1, 1, 'hD9, 0); rd_chk(1, 'h59, "R7");
    cyc(1, 4, 'hA3, 0); rd_chk(4, 'h23, "R7");
    cyc(1, 6, 'hFF, 0); rd_chk(6, 'h07, "R7");
    cyc(1, 8, 'hD5, 0); rd_chk(8, 'h15, "R7");
    cyc(1, 9, 'h32, 0); rd_chk(9, 'h12, "R7");
    cyc(1, 3, 'hAA, 0); rd_chk(3, 'h00, "R7");
    rd_chk(14, 'h00, "R7"); rd_chk(5, 'h00, "R7");
    cyc(1, 11, 'h00, 0); cyc(1, 6, 'hF9, 0); rd_chk(6, 'h01, "R7"); rd_chk(11, 'h00, "R7");
    cyc(1, 6, 'h03, 0); cyc(1, 11, 'h80, 0);

    tag = "R9";
    set_time('h00, 'h10, 'h20, 'h08, 2, 'h05, 'h06, 'h25);
    cyc(1, 11, 'h00, 0);
    ticks(50);
    rd_chk(0, 'h00, "R9"); rd_chk(11, 'h00, "R9");
    cyc(1, 11, 'h80, 0);
    rd_chk(0, 'h50, "R9"); rd_chk(1, 'h10, "R9");

    tag = "R10";
    cyc(1, 11, 'h00, 0);
    cyc(1, 2, 'h42, 0);
    rd_chk(2, 'h42, "R10");
    ticks(30);
    rd_chk(0, 'h50, "R10");
    cyc(1, 11, 'h80, 0);
    rd_chk(0, 'h80, "R10"); rd_chk(2, 'h42, "R10"); rd_chk(1, 'h10, "R10"); rd_chk(4, 'h08, "R10");

    tag = "R11";
    set_time('h99, 'h10, 'h20, 'h08, 2, 'h05, 'h06, 'h25);
    cyc(1, 1, 'h30, 1);
    rd_chk(1, 'h30, "R11"); rd_chk(0, 'h00, "R11"); rd_chk(2, 'h20, "R11");
    cyc(1, 11, 'h00, 0);
    cyc(1, 1, 'h05, 0);
    cyc(1, 11, 'h80, 1);
    rd_chk(0, 'h01, "R11"); rd_chk(1, 'h05, "R11");

    tag = "R8";
    cyc(0, 0, 0, 0);
    rst = 1;
    @(negedge clk); @(negedge clk);
    checks++;
    if (rdata != 8'h00) begin
      fails++;
      $display("FAIL R8 read during reset: actual %h expected 00", rdata);
    end
    rst = 0;
    rd_chk(11, 'h80, "R8");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule